// File: doc/BRIEF.md
# Programmable Pixel-Period Edge Generator

This block produces the fast clocks needed to read out a CCD line. A fast clock running at 48 times the pixel rate drives a position counter. The counter divides each pixel period into 48 slots. Inside every period the block produces these outputs:

- a reset-gate pulse;
- four horizontal clocks, where the second and fourth are the complements of the first and third;
- two single-slot sample strobes, one for the reset level and one for the data level;
- a single-slot strobe that sets the data-output phase;
- a pixel-start marker.

Each edge is set by a 6-bit code on a parallel configuration input. The two upper bits pick one of four quadrants of 12 slots. The four lower bits pick the slot inside that quadrant. A code whose lower bits are 12 to 15 is reported on an error bit and has no effect.

Configuration is sampled once per pixel period, in the last slot, so that every period runs on one coherent set of settings. All outputs are registered. An output shown in output phase p reflects the counter slot p. Phase 0 is the cycle in which `pixel_start` is high.

Top module: `pxg_edge_gen`

## Requirements
- R1: `pixel_start` is high for exactly one cycle in every 48. The first pulse comes in the first cycle after reset is released. That cycle is output phase 0, and the following cycles are phases 1 to 47.
- R2: A code c selects the slot 12·c[5:4] + c[3:0]. For example, code 0x25 selects slot 29 and code 0x3B selects slot 47.
- R3: In a given phase, `rg` equals the internal reset-gate level XOR `rg_invert`. The internal level goes to 1 in the phase of the rise slot and to 0 in the phase of the fall slot. In every other phase it keeps its value.
- R4: `h1` and `h3` follow the same rule using the shared `h_rise_code`, `h_fall_code` and `h_invert`, so `h1` and `h3` are always equal.
- R5: `h2` is always the complement of `h1`, and `h4` is always the complement of `h3`.
- R6: When the rise slot and the fall slot of a clock are equal, that clock keeps its previous level for the whole pixel period.
- R7: `shp_strobe`, `shd_strobe` and `dout_strobe` are each high for exactly one cycle per period. That cycle is the phase given by `shp_code`, `shd_code` and `dout_code` respectively.
- R8: A code whose lower four bits are 12 or more sets its bit in `code_err`. The bits are assigned as follows: 0 rg rise, 1 rg fall, 2 h rise, 3 h fall, 4 shp, 5 shd, 6 dout. The edge or strobe tied to that code does not occur. `code_err` changes only in phase 0.
- R9: Configuration inputs are sampled at the end of phase 47, and only then. A value changed in the middle of a period takes effect from phase 0 of the next period.
- R10: While `rst_n` is low, on each clock edge the outputs go to their inactive levels: `rg`, `h1` and `h3` are 0, `h2` and `h4` are 1, and every strobe and `code_err` are 0. The stored configuration is cleared to all-zero codes with no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 per pixel period |
| rst_n | input | 1 | Synchronous active-low reset |
| rg_rise_code | input | 6 | Reset-gate rising slot code |
| rg_fall_code | input | 6 | Reset-gate falling slot code |
| rg_invert | input | 1 | Reset-gate polarity, 1 inverts |
| h_rise_code | input | 6 | Horizontal clock rising slot code |
| h_fall_code | input | 6 | Horizontal clock falling slot code |
| h_invert | input | 1 | Horizontal clock polarity, 1 inverts |
| shp_code | input | 6 | Reset-level sample slot code |
| shd_code | input | 6 | Data-level sample slot code |
| dout_code | input | 6 | Data-output phase slot code |
| pixel_start | output | 1 | High in phase 0 of every period |
| rg | output | 1 | Reset-gate pulse |
| h1 | output | 1 | Horizontal clock 1 |
| h2 | output | 1 | Complement of h1 |
| h3 | output | 1 | Horizontal clock 3 |
| h4 | output | 1 | Complement of h3 |
| shp_strobe | output | 1 | Reset-level sample strobe |
| shd_strobe | output | 1 | Data-level sample strobe |
| dout_strobe | output | 1 | Data-output phase strobe |
| code_err | output | 7 | Illegal-code flags of the active configuration |

## Verification
A slip in the position counter moves every strobe and `pixel_start` away from its phase within one pixel period. The bench compares every output in every cycle, so a slip like this shows up within 48 cycles.

A wrong stored level in an edge clock shows at `rg` or `h1` in the very next cycle. It stays visible until the next programmed edge. A misdecoded quadrant shifts an edge by a multiple of 12 slots.

A shadow register that loads at the wrong time shows up as an edge in the old or new position during the period of a mid-period change. That error is caught in the same period.

// File: rtl/pxg_pkg.sv
// Package: shared constants and configuration type for the pixel-period
// edge generator. Assumes 6-bit edge codes split into quadrant and offset.
package pxg_pkg;
    localparam int unsigned CODE_W    = 6;
    localparam int unsigned QUAD_W    = 2;
    localparam int unsigned OFF_W     = CODE_W - QUAD_W;
    localparam int unsigned NUM_CODES = 7;

    localparam int unsigned IDX_RG_RISE = 0;
    localparam int unsigned IDX_RG_FALL = 1;
    localparam int unsigned IDX_H_RISE  = 2;
    localparam int unsigned IDX_H_FALL  = 3;
    localparam int unsigned IDX_SHP     = 4;
    localparam int unsigned IDX_SHD     = 5;
    localparam int unsigned IDX_DOUT    = 6;
    localparam int unsigned NUM_STROBES = 3;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic                        rg_inv;
        logic                        h_inv;
        logic [NUM_CODES-1:0][CODE_W-1:0] codes;
    } cfg_t;
endpackage

// File: rtl/pxg_code_decode.sv
// Module: turns one quadrant/offset edge code into a slot number.
// Assumes the upper QUAD_W bits select the quadrant and the rest the offset;
// offsets of QUAD_SIZE or more are reported as illegal.
module pxg_code_decode
    import pxg_pkg::*;
#(
    parameter int unsigned QUAD_SIZE = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] pos,
    output logic              legal
);
    logic [QUAD_W-1:0] quad;
    logic [OFF_W-1:0]  offs;

    // Split the code and form quadrant * size + offset.
    always_comb begin
        quad  = code[CODE_W-1 -: QUAD_W];
        offs  = code[OFF_W-1:0];
        pos   = CODE_W'(quad) * CODE_W'(QUAD_SIZE) + CODE_W'(offs);
        legal = (32'(offs) < QUAD_SIZE);
    end
endmodule

// File: rtl/pxg_pos_counter.sv
// Module: slot counter that runs 0 .. POSITIONS-1 and wraps.
// Assumes one increment per fast clock; synchronous active-low reset to 0.
module pxg_pos_counter
    import pxg_pkg::*;
#(
    parameter int unsigned POSITIONS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CODE_W-1:0] pos,
    output logic              at_first,
    output logic              at_last
);
    localparam logic [CODE_W-1:0] LAST = CODE_W'(POSITIONS - 1);

    logic [CODE_W-1:0] pos_q;

    // Advance the slot each cycle, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)             pos_q <= '0;
        else if (pos_q == LAST) pos_q <= '0;
        else                    pos_q <= pos_q + 1'b1;
    end

    assign pos      = pos_q;
    assign at_first = (pos_q == '0);
    assign at_last  = (pos_q == LAST);
endmodule

// File: rtl/pxg_edge_clock.sv
// Module: one programmable clock with rise slot, fall slot and polarity.
// Assumes slot numbers are already decoded; an illegal slot is never matched.
// When both edges land on the current slot, the level is held.
module pxg_edge_clock
    import pxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pos,
    input  logic [CODE_W-1:0] rise_pos,
    input  logic              rise_ok,
    input  logic [CODE_W-1:0] fall_pos,
    input  logic              fall_ok,
    input  logic              invert,
    output logic              clk_out
);
    logic level_q;
    logic level_d;
    logic out_q;
    logic hit_rise;
    logic hit_fall;

    // Work out the next internal level from the edge matches.
    always_comb begin
        hit_rise = rise_ok && (pos == rise_pos);
        hit_fall = fall_ok && (pos == fall_pos);
        if (hit_rise && hit_fall) level_d = level_q;
        else if (hit_rise)        level_d = 1'b1;
        else if (hit_fall)        level_d = 1'b0;
        else                      level_d = level_q;
    end

    // Hold the level and register the polarity-adjusted output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            level_q <= level_d;
            out_q   <= level_d ^ invert;
        end
    end

    assign clk_out = out_q;
endmodule

// File: rtl/pxg_strobe.sv
// Module: one-slot strobe, high for the cycle after its slot is reached.
// Assumes a decoded slot; an illegal code yields no strobe.
module pxg_strobe
    import pxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pos,
    input  logic [CODE_W-1:0] loc,
    input  logic              loc_ok,
    output logic              strobe
);
    logic strobe_q;

    // Fire once per period when the counter meets the programmed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= loc_ok && (pos == loc);
    end

    assign strobe = strobe_q;
endmodule

// File: rtl/pxg_edge_gen.sv
// Module: top of the pixel-period edge generator. It samples the configuration
// in the last slot of each period, decodes all codes, and drives the
// reset gate, the horizontal clocks, the strobes and the error flags.
// Assumes clk runs at POSITIONS times the pixel rate; synchronous active-low reset.
module pxg_edge_gen
    import pxg_pkg::*;
#(
    parameter int unsigned POSITIONS  = 48,
    parameter int unsigned QUAD_SIZE  = 12,
    parameter int unsigned H_CHANNELS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rg_rise_code,
    input  logic [CODE_W-1:0] rg_fall_code,
    input  logic              rg_invert,
    input  logic [CODE_W-1:0] h_rise_code,
    input  logic [CODE_W-1:0] h_fall_code,
    input  logic              h_invert,
    input  logic [CODE_W-1:0] shp_code,
    input  logic [CODE_W-1:0] shd_code,
    input  logic [CODE_W-1:0] dout_code,
    output logic              pixel_start,
    output logic              rg,
    output logic              h1,
    output logic              h2,
    output logic              h3,
    output logic              h4,
    output logic              shp_strobe,
    output logic              shd_strobe,
    output logic              dout_strobe,
    output logic [NUM_CODES-1:0] code_err
);
    cfg_t                              cfg_in;
    cfg_t                              cfg_q;
    logic [CODE_W-1:0]                 pos;
    logic                              at_first;
    logic                              at_last;
    logic [NUM_CODES-1:0][CODE_W-1:0]  dec_pos;
    logic [NUM_CODES-1:0]              dec_ok;
    logic [NUM_CODES-1:0]              err_q;
    logic                              start_q;
    logic [H_CHANNELS-1:0]             h_q;
    logic [NUM_STROBES-1:0]            strb;

    // Gather the configuration inputs into one record.
    always_comb begin
        cfg_in.rg_inv              = rg_invert;
        cfg_in.h_inv               = h_invert;
        cfg_in.codes[IDX_RG_RISE]  = rg_rise_code;
        cfg_in.codes[IDX_RG_FALL]  = rg_fall_code;
        cfg_in.codes[IDX_H_RISE]   = h_rise_code;
        cfg_in.codes[IDX_H_FALL]   = h_fall_code;
        cfg_in.codes[IDX_SHP]      = shp_code;
        cfg_in.codes[IDX_SHD]      = shd_code;
        cfg_in.codes[IDX_DOUT]     = dout_code;
    end

    pxg_pos_counter #(.POSITIONS(POSITIONS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .at_first (at_first),
        .at_last  (at_last)
    );

    // Shadow the configuration once per period, in its last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (at_last) cfg_q <= cfg_in;
    end

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_dec
        pxg_code_decode #(.QUAD_SIZE(QUAD_SIZE)) u_dec (
            .code  (cfg_q.codes[i]),
            .pos   (dec_pos[i]),
            .legal (dec_ok[i])
        );
    end

    // Register the period marker and the illegal-code flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            err_q   <= '0;
        end else begin
            start_q <= at_first;
            err_q   <= ~dec_ok;
        end
    end

    pxg_edge_clock u_rg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .rise_pos (dec_pos[IDX_RG_RISE]),
        .rise_ok  (dec_ok[IDX_RG_RISE]),
        .fall_pos (dec_pos[IDX_RG_FALL]),
        .fall_ok  (dec_ok[IDX_RG_FALL]),
        .invert   (cfg_q.rg_inv),
        .clk_out  (rg)
    );

    for (genvar j = 0; j < H_CHANNELS; j++) begin : g_h
        pxg_edge_clock u_h (
            .clk      (clk),
            .rst_n    (rst_n),
            .pos      (pos),
            .rise_pos (dec_pos[IDX_H_RISE]),
            .rise_ok  (dec_ok[IDX_H_RISE]),
            .fall_pos (dec_pos[IDX_H_FALL]),
            .fall_ok  (dec_ok[IDX_H_FALL]),
            .invert   (cfg_q.h_inv),
            .clk_out  (h_q[j])
        );
    end

    for (genvar k = 0; k < NUM_STROBES; k++) begin : g_strb
        pxg_strobe u_strb (
            .clk    (clk),
            .rst_n  (rst_n),
            .pos    (pos),
            .loc    (dec_pos[IDX_SHP + k]),
            .loc_ok (dec_ok[IDX_SHP + k]),
            .strobe (strb[k])
        );
    end

    assign pixel_start = start_q;
    assign h1          = h_q[0];
    assign h2          = ~h_q[0];
    assign h3          = h_q[H_CHANNELS-1];
    assign h4          = ~h_q[H_CHANNELS-1];
    assign shp_strobe  = strb[0];
    assign shd_strobe  = strb[1];
    assign dout_strobe = strb[2];
    assign code_err    = err_q;
endmodule

// File: rtl/pxg_edge_gen_chk.sv
// Module: protocol checker for the edge generator, attached by bind.
// Assumes it sees only the top-level ports.
module pxg_edge_gen_chk
    import pxg_pkg::*;
#(
    parameter int unsigned POSITIONS = 48
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pixel_start,
    input logic                 h1,
    input logic                 h3,
    input logic                 shp_strobe,
    input logic                 shd_strobe,
    input logic                 dout_strobe,
    input logic [NUM_CODES-1:0] code_err
);
    logic [15:0] gap_q;
    logic        seen_q;

    // Count cycles since the last period marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pixel_start) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R1
    period_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (pixel_start == (32'(gap_q) == POSITIONS - 1)));

    // R4
    h_pair_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h1 == h3);

    // R7
    shp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shp_strobe |=> !shp_strobe);

    // R7
    shd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shd_strobe |=> !shd_strobe);

    // R7
    dout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_strobe |=> !dout_strobe);

    // R8
    err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pixel_start |-> $stable(code_err));

    // R8
    shp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err[IDX_SHP] |-> !shp_strobe);

    // R8
    dout_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err[IDX_DOUT] |-> !dout_strobe);
endmodule

bind pxg_edge_gen pxg_edge_gen_chk #(.POSITIONS(POSITIONS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pixel_start (pixel_start),
    .h1          (h1),
    .h3          (h3),
    .shp_strobe  (shp_strobe),
    .shd_strobe  (shd_strobe),
    .dout_strobe (dout_strobe),
    .code_err    (code_err)
);

// File: tb/test_pxg_edge_gen.sv
// Bench: directed scenarios with a cycle-accurate expectation model built
// from the requirements, compared at every falling edge.
module test_pxg_edge_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] drv_code [7];
    logic drv_rg_inv = 1'b0;
    logic drv_h_inv  = 1'b0;

    logic pixel_start, rg, h1, h2, h3, h4, shp_strobe, shd_strobe, dout_strobe;
    logic [6:0] code_err;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_en   = 1'b0;
    string cur_req  = "R10";

    always #2.5 clk = ~clk;

    pxg_edge_gen i_pxg_edge_gen (
        .clk(clk), .rst_n(rst_n),
        .rg_rise_code(drv_code[0]), .rg_fall_code(drv_code[1]), .rg_invert(drv_rg_inv),
        .h_rise_code(drv_code[2]), .h_fall_code(drv_code[3]), .h_invert(drv_h_inv),
        .shp_code(drv_code[4]), .shd_code(drv_code[5]), .dout_code(drv_code[6]),
        .pixel_start(pixel_start), .rg(rg), .h1(h1), .h2(h2), .h3(h3), .h4(h4),
        .shp_strobe(shp_strobe), .shd_strobe(shd_strobe), .dout_strobe(dout_strobe),
        .code_err(code_err)
    );

    // Requirement-level helpers: slot of a code (R2) and its legality (R8).
    function automatic int slot_of(input logic [5:0] c);
        return int'(c[5:4]) * 12 + int'(c[3:0]);
    endfunction
    function automatic bit legal(input logic [5:0] c);
        return c[3:0] < 4'd12;
    endfunction
    function automatic bit next_lev(input bit lev, input int s,
                                    input logic [5:0] rc, input logic [5:0] fc);
        bit r, f;
        r = legal(rc) && slot_of(rc) == s;
        f = legal(fc) && slot_of(fc) == s;
        if (r && f) return lev;
        if (r)      return 1'b1;
        if (f)      return 1'b0;
        return lev;
    endfunction
    function automatic logic [5:0] enc(input int s);
        return {2'(s / 12), 4'(s % 12)};
    endfunction

    // Expectation model.
    int         m_slot = 0;
    int         e_phase = 0;
    logic [5:0] m_code [7];
    bit         m_rg_inv, m_h_inv, m_rg_lev, m_h_lev;
    bit         e_ps, e_rg, e_h, e_shp, e_shd, e_dout;
    logic [6:0] e_err;

    always @(posedge clk) begin
        bit nrg, nh;
        if (!rst_n) begin
            m_slot <= 0; e_phase <= 0;
            for (int i = 0; i < 7; i++) m_code[i] <= 6'd0;
            m_rg_inv <= 0; m_h_inv <= 0; m_rg_lev <= 0; m_h_lev <= 0;
            e_ps <= 0; e_rg <= 0; e_h <= 0; e_shp <= 0; e_shd <= 0; e_dout <= 0;
            e_err <= 7'd0;
        end else begin
            nrg = next_lev(m_rg_lev, m_slot, m_code[0], m_code[1]);
            nh  = next_lev(m_h_lev,  m_slot, m_code[2], m_code[3]);
            m_rg_lev <= nrg;
            m_h_lev  <= nh;
            e_rg   <= nrg ^ m_rg_inv;
            e_h    <= nh ^ m_h_inv;
            e_ps   <= (m_slot == 0);
            e_shp  <= legal(m_code[4]) && slot_of(m_code[4]) == m_slot;
            e_shd  <= legal(m_code[5]) && slot_of(m_code[5]) == m_slot;
            e_dout <= legal(m_code[6]) && slot_of(m_code[6]) == m_slot;
            for (int i = 0; i < 7; i++) e_err[i] <= !legal(m_code[i]);
            e_phase <= m_slot;
            if (m_slot == 47) begin
                for (int i = 0; i < 7; i++) m_code[i] <= drv_code[i];
                m_rg_inv <= drv_rg_inv;
                m_h_inv  <= drv_h_inv;
                m_slot   <= 0;
            end else begin
                m_slot <= m_slot + 1;
            end
        end
    end

    task automatic chk(input logic [6:0] got, input logic [6:0] exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (phase %0d)", cur_req, what, got, exp, e_phase);
        end
    endtask

    // Continuous per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(7'(pixel_start), 7'(e_ps),   "R1 pixel_start");
            chk(7'(rg),          7'(e_rg),   "R3 rg");
            chk(7'(h1),          7'(e_h),    "R4 h1");
            chk(7'(h3),          7'(e_h),    "R4 h3");
            chk(7'(h2),          7'(!e_h),   "R5 h2");
            chk(7'(h4),          7'(!e_h),   "R5 h4");
            chk(7'(shp_strobe),  7'(e_shp),  "R7 shp");
            chk(7'(shd_strobe),  7'(e_shd),  "R7 shd");
            chk(7'(dout_strobe), 7'(e_dout), "R7 dout");
            chk(code_err,        e_err,      "R8 code_err");
        end
    end

    task automatic wait_phase(input int p);
        do @(negedge clk); while (e_phase != p);
    endtask
    task automatic settle();
        wait_phase(10);
        wait_phase(0);
    endtask
    task automatic set_cfg(input int rr, input int rf, input int hr, input int hf,
                           input int sp, input int sd, input int dq);
        drv_code[0] = enc(rr); drv_code[1] = enc(rf);
        drv_code[2] = enc(hr); drv_code[3] = enc(hf);
        drv_code[4] = enc(sp); drv_code[5] = enc(sd); drv_code[6] = enc(dq);
    endtask

    task automatic t_reset();
        cur_req = "R10";
        for (int i = 0; i < 7; i++) drv_code[i] = 6'd0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(7'(rg), 7'd0, "R10 rg in reset");
        chk(7'(h1), 7'd0, "R10 h1 in reset");
        chk(7'(h2), 7'd1, "R10 h2 in reset");
        chk(7'(h4), 7'd1, "R10 h4 in reset");
        chk(7'({shp_strobe, shd_strobe, dout_strobe, pixel_start}), 7'd0, "R10 strobes in reset");
        chk(code_err, 7'd0, "R10 code_err in reset");
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        chk(7'(pixel_start), 7'd1, "R1 first pixel_start after reset");
    endtask

    task automatic t_basic();
        int gap;
        cur_req = "R3";
        set_cfg(3, 9, 0, 24, 14, 38, 45);
        settle();
        chk(7'(rg), 7'd0, "R3 rg before rise");
        wait_phase(3);
        chk(7'(rg), 7'd1, "R3 rg at rise slot");
        wait_phase(9);
        chk(7'(rg), 7'd0, "R3 rg at fall slot");
        wait_phase(14);
        chk(7'(shp_strobe), 7'd1, "R7 shp at slot 14");
        cur_req = "R1";
        wait_phase(0);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!pixel_start && gap < 100);
        chk(7'(gap), 7'd48, "R1 period length");
    endtask

    task automatic t_quadrants();
        cur_req = "R2";
        drv_code[0] = 6'h25; drv_code[1] = 6'h33;
        drv_code[4] = 6'h3B; drv_code[6] = 6'h10;
        settle();
        wait_phase(28);
        chk(7'(rg), 7'd0, "R2 rg before slot 29");
        wait_phase(29);
        chk(7'(rg), 7'd1, "R2 rg rises at code 0x25");
        wait_phase(39);
        chk(7'(rg), 7'd0, "R2 rg falls at code 0x33");
        wait_phase(47);
        chk(7'(shp_strobe), 7'd1, "R2 shp at code 0x3B");
    endtask

    task automatic t_polarity();
        cur_req = "R4";
        drv_rg_inv = 1'b1; drv_h_inv = 1'b1;
        settle();
        wait_phase(30);
        chk(7'(rg), 7'd0, "R3 inverted rg while level high");
        wait_phase(5);
        chk(7'(h1), 7'd0, "R4 inverted h1 while level high");
        chk(7'(h2), 7'd1, "R5 h2 complement under inversion");
        drv_rg_inv = 1'b0; drv_h_inv = 1'b0;
        settle();
    endtask

    task automatic t_equal();
        cur_req = "R6";
        drv_code[2] = enc(30); drv_code[3] = enc(5);
        settle();
        drv_code[2] = enc(10); drv_code[3] = enc(10);
        settle();
        wait_phase(10);
        chk(7'(h1), 7'd1, "R6 h1 holds at equal slot");
        wait_phase(40);
        chk(7'(h1), 7'd1, "R6 h1 still held late in period");
    endtask

    task automatic t_illegal();
        int cnt;
        cur_req = "R8";
        drv_code[0] = 6'h1F; drv_code[1] = enc(20); drv_code[4] = 6'h0C;
        settle();
        wait_phase(1);
        chk(code_err, 7'b0010001, "R8 flags for rg rise and shp");
        cnt = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (shp_strobe) cnt++;
        end
        chk(7'(cnt), 7'd0, "R8 illegal shp never strobes");
        wait_phase(30);
        chk(7'(rg), 7'd0, "R8 illegal rise ignored");
        drv_code[0] = enc(2); drv_code[4] = enc(7);
        settle();
        cur_req = "R7";
        cnt = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (shp_strobe) cnt++;
        end
        chk(7'(cnt), 7'd1, "R7 one shp strobe per period");
    endtask

    task automatic t_midpixel();
        cur_req = "R9";
        drv_code[0] = enc(30); drv_code[1] = enc(40);
        settle();
        wait_phase(20);
        drv_code[0] = enc(5); drv_code[1] = enc(10);
        wait_phase(30);
        chk(7'(rg), 7'd1, "R9 old rise still used in current period");
        wait_phase(0);
        wait_phase(4);
        chk(7'(rg), 7'd0, "R9 low before new rise");
        wait_phase(5);
        chk(7'(rg), 7'd1, "R9 new rise from next period");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_quadrants();
        t_polarity();
        t_equal();
        t_illegal();
        t_midpixel();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule